// File: doc/BRIEF.md
# Dual-Path Control Word Loader

This block is the host-side programming port of a frequency synthesizer. A host builds one 40-bit control word in a staging register. It can do this with byte-wide writes or with single-bit shifts. An update strobe then moves the staged word into the active registers. The active registers drive a 32-bit frequency word, a 5-bit phase word and a power-down bit into the rest of the synthesizer.

The write strobe and the update strobe are level inputs from outside the core clock domain. Each one passes through a two-flop synchronizer followed by a rising-edge detector. A level held high for many core cycles therefore counts as one event. A mode input picks the path.

- In byte mode, a pointer chooses which of the five byte slots the next write fills. The pointer stops after the fifth slot.
- In bit mode, each write shifts the most significant data line into the word, least significant frequency bit first.

An update always returns the pointer and the bit count to zero. An update is refused in two cases: the staged word carries a non-zero test-control field, or fewer than 40 bits have been shifted in bit mode. When an update is refused, the active registers keep their value and an error output is raised.

Top module: `ctrl_word_loader`

## Requirements
- R1: While `rst` is high at a clock edge, the active frequency, phase and power-down outputs and `code_error` clear to zero. The staging register, the byte pointer and the bit count also clear, so the next byte write after reset fills byte slot 0.
- R2: In byte mode, slot 0 carries the phase word in data bits [7:3], power-down in bit 2 and the two test-control bits in bits [1:0].
- R3: In byte mode, slots 1, 2, 3 and 4 carry frequency bits [31:24], [23:16], [15:8] and [7:0], in that order.
- R4: Each byte write fills the pointed slot and advances the pointer. Once all five slots are written, further writes change nothing until an update or a reset.
- R5: A rising update strobe copies the staged word to the outputs and returns the pointer to slot 0. The outputs change on the third clock edge after the strobe rises.
- R6: An update after fewer than five byte writes commits the staged word. Slots not rewritten keep their earlier contents.
- R7: In bit mode, each write shifts `data_in[7]` into the word. After 40 shifts, the first bit shifted is frequency bit 0 and bits 0–31 are frequency (LSB first). Bits 32–33 are test control, bit 34 is power-down, and bits 35–39 are phase bits 0–4.
- R8: In bit mode, an update that comes after fewer than 40 shifts is refused. The outputs hold their value and `code_error` goes to 1.
- R9: An update whose staged test-control field is non-zero (01, 10 or 11) is refused. The outputs hold their value and `code_error` goes to 1. Any accepted update clears `code_error` to 0.
- R10: The outputs and `code_error` change only on an update or a reset. Writes alone never move them.
- R11: A strobe held high for many cycles counts as exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 1 selects bit-shift loading, 0 selects byte loading |
| wr_clk | input | 1 | Asynchronous write strobe; the rising edge acts |
| upd_strobe | input | 1 | Asynchronous update strobe; the rising edge commits |
| data_in | input | 8 | Byte data; bit 7 is the serial data line |
| freq_word | output | 32 | Active frequency word |
| phase_word | output | 5 | Active phase word |
| power_down | output | 1 | Active power-down bit |
| code_error | output | 1 | Last update was refused |

## Verification
Known byte patterns confirm where each slot lands, which separates a wrong slot order from a wrong bit order within slot 0. Random words loaded through both paths and compared with a bench model show that the two layouts describe the same word. Directed cases cover the following:
- a sixth write;
- a partial rewrite;
- a strobe held high for a long time;
- an update after 20 shifts;
- each non-zero control code.

Each of these cases separates a refusal or a saturation from a plain commit.

// File: rtl/cwl_pkg.sv
package cwl_pkg;

    localparam int FREQ_W    = 32;
    localparam int PHASE_W   = 5;
    localparam int CTL_W     = 2;
    localparam int BUS_W     = 8;
    localparam int WORD_W    = FREQ_W + PHASE_W + 1 + CTL_W;
    localparam int NUM_BYTES = WORD_W / BUS_W;
    localparam int PTR_W     = $clog2(NUM_BYTES + 1);
    localparam int CNT_W     = $clog2(WORD_W + 1);

    // Layout equals the bit-shift order (bit 0 first in) and, read as
    // bytes from the top, the byte-slot order.
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               pdown;
        logic [CTL_W-1:0]   ctl;
        logic [FREQ_W-1:0]  freq;
    } ctrl_word_t;

    function automatic logic code_reserved(ctrl_word_t w);
        return w.ctl != '0;
    endfunction

endpackage

// File: rtl/cwl_edge_sync.sv
module cwl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < DEPTH; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign rise_o = chain[STAGES-1] & ~chain[STAGES];

    // A single edge never yields two consecutive events.
    assert_single_event_R11: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/cwl_assembler.sv
module cwl_assembler
    import cwl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             serial_mode,
    input  logic             wr_pulse,
    input  logic             upd_pulse,
    input  logic [BUS_W-1:0] data_in,
    output ctrl_word_t       stage_o,
    output logic             shift_done_o
);
    logic [WORD_W-1:0] stage_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            ptr_q   <= '0;
            cnt_q   <= '0;
        end else if (upd_pulse) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (wr_pulse) begin
            if (serial_mode) begin
                stage_q <= {data_in[BUS_W-1], stage_q[WORD_W-1:1]};
                if (cnt_q != CNT_W'(WORD_W)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (ptr_q != PTR_W'(NUM_BYTES)) begin
                for (int b = 0; b < NUM_BYTES; b++) begin
                    if (ptr_q == PTR_W'(b)) begin
                        stage_q[WORD_W-1-b*BUS_W -: BUS_W] <= data_in;
                    end
                end
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign stage_o      = ctrl_word_t'(stage_q);
    assign shift_done_o = (cnt_q == CNT_W'(WORD_W));

    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= PTR_W'(NUM_BYTES));

    assert_saturated_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && !upd_pulse && !serial_mode && ptr_q == PTR_W'(NUM_BYTES))
        |=> $stable(stage_q) && ptr_q == PTR_W'(NUM_BYTES));

    assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && !upd_pulse && !serial_mode && ptr_q < PTR_W'(NUM_BYTES))
        |=> ptr_q == $past(ptr_q) + 1'b1);

    assert_rewind_R5: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |=> ptr_q == '0 && cnt_q == '0);

endmodule

// File: rtl/cwl_commit.sv
module cwl_commit
    import cwl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       serial_mode,
    input  logic       upd_pulse,
    input  ctrl_word_t stage_i,
    input  logic       shift_done_i,
    output ctrl_word_t active_o,
    output logic       err_o
);
    ctrl_word_t act_q;
    logic       err_q;
    logic       refuse;

    assign refuse = code_reserved(stage_i) || (serial_mode && !shift_done_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            err_q <= 1'b0;
        end else if (upd_pulse) begin
            err_q <= refuse;
            if (!refuse) begin
                act_q <= stage_i;
            end
        end
    end

    assign active_o = act_q;
    assign err_o    = err_q;

    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !upd_pulse |=> $stable(act_q) && $stable(err_q));

    assert_reserved_R9: assert property (@(posedge clk) disable iff (rst)
        (upd_pulse && stage_i.ctl != '0) |=> err_q && $stable(act_q));

    assert_short_shift_R8: assert property (@(posedge clk) disable iff (rst)
        (upd_pulse && serial_mode && !shift_done_i) |=> err_q && $stable(act_q));

    assert_commit_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_pulse && !serial_mode && stage_i.ctl == '0)
        |=> act_q == $past(stage_i) && !err_q);

endmodule

// File: rtl/ctrl_word_loader.sv
module ctrl_word_loader
    import cwl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               serial_mode,
    input  logic               wr_clk,
    input  logic               upd_strobe,
    input  logic [BUS_W-1:0]   data_in,
    output logic [FREQ_W-1:0]  freq_word,
    output logic [PHASE_W-1:0] phase_word,
    output logic               power_down,
    output logic               code_error
);
    logic       wr_pulse;
    logic       upd_pulse;
    ctrl_word_t stage;
    logic       shift_done;
    ctrl_word_t active;

    cwl_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (wr_clk),
        .rise_o   (wr_pulse)
    );

    cwl_edge_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (upd_strobe),
        .rise_o   (upd_pulse)
    );

    cwl_assembler u_asm (
        .clk          (clk),
        .rst          (rst),
        .serial_mode  (serial_mode),
        .wr_pulse     (wr_pulse),
        .upd_pulse    (upd_pulse),
        .data_in      (data_in),
        .stage_o      (stage),
        .shift_done_o (shift_done)
    );

    cwl_commit u_commit (
        .clk          (clk),
        .rst          (rst),
        .serial_mode  (serial_mode),
        .upd_pulse    (upd_pulse),
        .stage_i      (stage),
        .shift_done_i (shift_done),
        .active_o     (active),
        .err_o        (code_error)
    );

    assign freq_word  = active.freq;
    assign phase_word = active.phase;
    assign power_down = active.pdown;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> freq_word == '0 && phase_word == '0 && !power_down && !code_error);

endmodule

// File: tb/test_ctrl_word_loader.sv
module test_ctrl_word_loader;

    logic       clk = 1'b0;
    logic       rst;
    logic       serial_mode;
    logic       wr_clk;
    logic       upd_strobe;
    logic [7:0] data_in;
    logic [31:0] freq_word;
    logic [4:0]  phase_word;
    logic        power_down;
    logic        code_error;

    always #2 clk = ~clk;

    ctrl_word_loader i_ctrl_word_loader (
        .clk        (clk),
        .rst        (rst),
        .serial_mode(serial_mode),
        .wr_clk     (wr_clk),
        .upd_strobe (upd_strobe),
        .data_in    (data_in),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .power_down (power_down),
        .code_error (code_error)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Bench model of the word, laid out {phase, pd, ctl, freq}.
    logic [39:0] m_stage;
    logic [39:0] m_act;
    logic        m_err;
    int          m_ptr;
    int          m_cnt;

    function automatic logic [39:0] make_word(logic [31:0] f, logic [4:0] p,
                                              logic pd, logic [1:0] c);
        return {p, pd, c, f};
    endfunction

    function automatic logic [7:0] slot_of(logic [39:0] w, int k);
        return w[39-8*k -: 8];
    endfunction

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        m_stage = '0; m_act = '0; m_err = 1'b0; m_ptr = 0; m_cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        model_reset();
        idle(2);
    endtask

    task automatic write(logic [7:0] d, int hold = 4);
        @(negedge clk);
        data_in = d;
        wr_clk  = 1'b1;
        idle(hold);
        wr_clk  = 1'b0;
        idle(4);
        if (serial_mode) begin
            m_stage = {d[7], m_stage[39:1]};
            if (m_cnt < 40) m_cnt++;
        end else if (m_ptr < 5) begin
            m_stage[39-8*m_ptr -: 8] = d;
            m_ptr++;
        end
    endtask

    task automatic update();
        logic refuse;
        @(negedge clk);
        upd_strobe = 1'b1;
        idle(4);
        upd_strobe = 1'b0;
        idle(4);
        refuse = (m_stage[33:32] != 2'b00) || (serial_mode && m_cnt < 40);
        m_err  = refuse;
        if (!refuse) m_act = m_stage;
        m_ptr = 0;
        m_cnt = 0;
    endtask

    task automatic check(string req);
        logic [39:0] got;
        checks++;
        got = {phase_word, power_down, 2'b00, freq_word};
        if (got != {m_act[39:34], 2'b00, m_act[31:0]} || code_error !== m_err) begin
            errors++;
            $display("FAIL %s: got freq=%h phase=%h pd=%b err=%b expected freq=%h phase=%h pd=%b err=%b",
                     req, freq_word, phase_word, power_down, code_error,
                     m_act[31:0], m_act[39:35], m_act[34], m_err);
        end
    endtask

    task automatic load_bytes(logic [39:0] w);
        for (int k = 0; k < 5; k++) write(slot_of(w, k));
    endtask

    task automatic load_bits(logic [39:0] w, int n);
        for (int i = 0; i < n; i++) write({w[i], 7'b0});
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [39:0] w;
        void'($urandom(32'd1357));
        rst = 1'b1; serial_mode = 1'b0; wr_clk = 1'b0; upd_strobe = 1'b0; data_in = '0;
        model_reset();
        idle(4);
        rst = 1'b0;
        idle(2);
        check("R1 reset state");

        // R2 R3: known word through the byte path
        w = make_word(32'h12345678, 5'h15, 1'b1, 2'b00);
        load_bytes(w);
        check("R10 writes leave outputs");
        update();
        check("R2 R3 byte layout");
        if (freq_word !== 32'h12345678 || phase_word !== 5'h15 || power_down !== 1'b1) begin
            errors++;
            $display("FAIL R2: got %h/%h/%b expected 12345678/15/1", freq_word, phase_word, power_down);
        end
        checks++;

        // R4: sixth write ignored
        load_bytes(make_word(32'hCAFEF00D, 5'h03, 1'b0, 2'b00));
        write(8'hFF);
        update();
        check("R4 sixth write ignored");

        // R5 R6: partial rewrite of slot 0 only
        write(8'h08);
        update();
        check("R5 R6 partial update");

        // R11: long strobe counts once; next write lands in slot 1
        write(8'h10, 25);
        write(8'hA5);
        update();
        check("R11 long strobe single write");

        // R9: reserved codes in byte mode
        write(8'h01);
        update();
        check("R9 code 01 refused");
        write(8'h02);
        update();
        check("R9 code 10 refused");
        write(8'h00);
        update();
        check("R9 accepted update clears error");

        // R1: reset mid-load
        write(8'h77);
        write(8'h66);
        do_reset();
        check("R1 reset mid-load");
        write(8'hF8);
        update();
        check("R1 pointer back to slot 0");

        // R7 R8 R9: bit path
        serial_mode = 1'b1;
        w = make_word(32'h89ABCDEF, 5'h0B, 1'b1, 2'b00);
        load_bits(w, 40);
        update();
        check("R7 serial layout");
        load_bits(make_word(32'h0F0F0F0F, 5'h1F, 1'b0, 2'b00), 20);
        update();
        check("R8 short shift refused");
        load_bits(make_word(32'h11112222, 5'h04, 1'b0, 2'b11), 40);
        update();
        check("R9 serial code 11 refused");
        load_bits(make_word(32'h33334444, 5'h04, 1'b0, 2'b01), 40);
        update();
        check("R9 serial code 01 refused");

        // Random mix of both paths
        for (int it = 0; it < 24; it++) begin
            logic [1:0] c;
            c = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
            w = make_word($urandom, 5'($urandom), 1'($urandom), c);
            serial_mode = it[0];
            if (serial_mode) load_bits(w, 40);
            else load_bytes(w);
            update();
            check(serial_mode ? "R7 R9 random serial" : "R3 R9 random bytes");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule